// File: doc/BRIEF.md
# Byte-Enabled Conversion Result Port

This block keeps the most recent conversion result from a converter sequencer and lets a host read it one byte at a time over a shared 8-bit bus. The result is a 12-bit magnitude with a sign (polarity) flag and an overrange flag. The register is written only when the sequencer pulses its load strobe, so a reader never sees a result that has been half updated.

The host reads through three active-low selects: a chip select and one select for each byte. The block drives the bus only while direct access is enabled (mode input low) and the chip select and that byte's select are both low. The bus is modelled as a data vector and an output-enable. When the output-enable is low the data vector is forced to zero, and the pad ring turns this pair into a three-state driver. Enables that are left unconnected are expected to be pulled high at the pad, so a logic 1 on an enable deselects.

The numeric byte carries magnitude bits 1 to 8. The upper byte packs magnitude bits 9 to 12 with the two flags.

Top module: `res_byte_port`

## Requirements
- R1: After synchronous reset the stored result is all zero, so both bytes read 0x00.
- R2: When `load_i` is high at a rising clock edge, the magnitude and both flags are stored at that edge and can be read in the following cycle.
- R3: When `load_i` is low, the stored result keeps its value however the result inputs change.
- R4: The numeric byte holds magnitude bits 1..8 in bus positions [7:0], with `mag_i[0]` (bit 1) in position 0.
- R5: The upper byte holds magnitude bits 9..12 (`mag_i[11:8]`) in positions [3:0], zero in [5:4], the overrange flag in [6] and the polarity flag in [7].
- R6: `bus_oe_o` is high only when `mode_i` is 0, `cs_n_i` is 0 and at least one byte select is 0. With `cs_n_i` at 1 or both byte selects at 1, it is low.
- R7: When `mode_i` is 1, the bus is never driven, whatever the selects are.
- R8: When both byte selects are low together, the numeric byte is driven.
- R9: Whenever `bus_oe_o` is low, `bus_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Result-load strobe from the sequencer |
| mag_i | input | 12 | Conversion magnitude; bit 0 is result bit 1 |
| pol_i | input | 1 | Polarity flag of the result |
| ovr_i | input | 1 | Overrange flag of the result |
| mode_i | input | 1 | Access mode; 0 enables direct byte reads |
| cs_n_i | input | 1 | Chip select, active low |
| lo_sel_n_i | input | 1 | Numeric-byte select, active low |
| hi_sel_n_i | input | 1 | Upper-byte select, active low |
| bus_o | output | 8 | Read data bus |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
The only state is the stored result word. A wrong value there shows up on the very next read of either byte, because the bus output depends combinationally on the word and the selects. Loads are therefore checked one cycle after the strobe through both byte views. A corrupted hold shows up on any read made after the result inputs change while no strobe is given. Select decoding and the priority between lanes have no state, so a decode error shows up in the same cycle the selects are applied.

// File: rtl/res_port_pkg.sv
package res_port_pkg;

    localparam int MAG_W   = 12;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = MAG_W - BYTE_W;
    localparam int OVR_BIT = 6;
    localparam int POL_BIT = 7;
    localparam int N_LANES = 2;
    localparam int LANE_LO = 0;   // lower index wins the bus
    localparam int LANE_HI = 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic             pol;
        logic             ovr;
        logic [MAG_W-1:0] mag;
    } res_word_t;

    function automatic byte_t lo_view(input res_word_t w);
        return w.mag[BYTE_W-1:0];
    endfunction

    function automatic byte_t hi_view(input res_word_t w);
        byte_t b;
        b             = '0;
        b[HI_W-1:0]   = w.mag[MAG_W-1:BYTE_W];
        b[OVR_BIT]    = w.ovr;
        b[POL_BIT]    = w.pol;
        return b;
    endfunction

endpackage

// File: rtl/res_word_reg.sv
module res_word_reg
    import res_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  res_word_t d_i,
    output res_word_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/res_lane_sel.sv
module res_lane_sel
    import res_port_pkg::*;
#(
    parameter int LANES = N_LANES
) (
    input  logic             mode_i,
    input  logic             cs_n_i,
    input  logic [LANES-1:0] sel_n_i,
    input  byte_t            lanes_i [LANES],
    output byte_t            bus_o,
    output logic             oe_o
);

    logic             direct;
    logic [LANES-1:0] req;

    assign direct = (mode_i == 1'b0) && (cs_n_i == 1'b0);

    for (genvar g = 0; g < LANES; g++) begin : g_req
        assign req[g] = direct && (sel_n_i[g] == 1'b0);
    end

    // Walk from the highest lane down so the lowest requesting lane is kept.
    always_comb begin
        bus_o = '0;
        oe_o  = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req[i]) begin
                bus_o = lanes_i[i];
                oe_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/res_byte_port.sv
module res_byte_port
    import res_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              pol_i,
    input  logic              ovr_i,
    input  logic              mode_i,
    input  logic              cs_n_i,
    input  logic              lo_sel_n_i,
    input  logic              hi_sel_n_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o
);

    res_word_t          word_d;
    res_word_t          word_q;
    byte_t              lanes [N_LANES];
    logic [N_LANES-1:0] sel_n;
    byte_t              bus_w;

    assign word_d = '{pol: pol_i, ovr: ovr_i, mag: mag_i};

    res_word_reg u_word (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .d_i    (word_d),
        .q_o    (word_q)
    );

    assign lanes[LANE_LO] = lo_view(word_q);
    assign lanes[LANE_HI] = hi_view(word_q);
    assign sel_n[LANE_LO] = lo_sel_n_i;
    assign sel_n[LANE_HI] = hi_sel_n_i;

    res_lane_sel #(.LANES(N_LANES)) u_sel (
        .mode_i  (mode_i),
        .cs_n_i  (cs_n_i),
        .sel_n_i (sel_n),
        .lanes_i (lanes),
        .bus_o   (bus_w),
        .oe_o    (bus_oe_o)
    );

    assign bus_o = bus_w;

endmodule

// File: rtl/res_port_chk.sv
module res_port_chk
    import res_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [MAG_W-1:0]  mag_i,
    input logic              pol_i,
    input logic              ovr_i,
    input logic              mode_i,
    input logic              cs_n_i,
    input logic              lo_sel_n_i,
    input logic              hi_sel_n_i,
    input logic [BYTE_W-1:0] bus_o,
    input logic              bus_oe_o,
    input res_word_t         word_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word_q == '0)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (word_q.mag == $past(mag_i) && word_q.pol == $past(pol_i)
                    && word_q.ovr == $past(ovr_i))); // R2

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(word_q)); // R3

    AST_HI_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_o && lo_sel_n_i) |-> (bus_o[5:4] == 2'b00
            && bus_o[3:0] == word_q.mag[MAG_W-1:BYTE_W]
            && bus_o[OVR_BIT] == word_q.ovr && bus_o[POL_BIT] == word_q.pol)); // R5

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i || (lo_sel_n_i && hi_sel_n_i)) |-> !bus_oe_o); // R6

    AST_MODE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> !bus_oe_o); // R7

    AST_LO_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !cs_n_i && !lo_sel_n_i) |-> (bus_oe_o
            && bus_o == word_q.mag[BYTE_W-1:0])); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (bus_o == '0)); // R9

endmodule

bind res_byte_port res_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .mag_i      (mag_i),
    .pol_i      (pol_i),
    .ovr_i      (ovr_i),
    .mode_i     (mode_i),
    .cs_n_i     (cs_n_i),
    .lo_sel_n_i (lo_sel_n_i),
    .hi_sel_n_i (hi_sel_n_i),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .word_q     (word_q)
);

// File: tb/res_byte_port_tb_top.sv
`timescale 1ns/1ps
module res_byte_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [11:0] mag_i = '0;
    logic        pol_i = 1'b0;
    logic        ovr_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        lo_sel_n_i = 1'b1;
    logic        hi_sel_n_i = 1'b1;
    logic [7:0]  bus_o;
    logic        bus_oe_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    res_byte_port dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .mag_i(mag_i),
        .pol_i(pol_i), .ovr_i(ovr_i), .mode_i(mode_i), .cs_n_i(cs_n_i),
        .lo_sel_n_i(lo_sel_n_i), .hi_sel_n_i(hi_sel_n_i),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o)
    );

    // {mag[11:0], pol, ovr, expected numeric byte, expected upper byte}
    localparam logic [29:0] VEC [5] = '{
        {12'hA5C, 1'b1, 1'b0, 8'h5C, 8'h8A},
        {12'h3FF, 1'b0, 1'b1, 8'hFF, 8'h43},
        {12'hFFF, 1'b1, 1'b1, 8'hFF, 8'hCF},
        {12'h001, 1'b0, 1'b0, 8'h01, 8'h00},
        {12'h800, 1'b0, 1'b0, 8'h00, 8'h08}
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual oe/data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [11:0] m, input logic p, input logic o);
        @(negedge clk);
        mag_i = m; pol_i = p; ovr_i = o; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Apply selects away from the edge and sample 1 ns later.
    task automatic rd(input logic md, input logic cs, input logic lo, input logic hi,
                      output logic [8:0] r);
        @(negedge clk);
        mode_i = md; cs_n_i = cs; lo_sel_n_i = lo; hi_sel_n_i = hi;
        #1;
        r = {bus_oe_o, bus_o};
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [8:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 0, 0, 1, r); check("R1 lo", r, {1'b1, 8'h00});
        rd(0, 0, 1, 0, r); check("R1 hi", r, {1'b1, 8'h00});

        // Vector table: R2 load, R4/R5 layouts
        for (int k = 0; k < 5; k++) begin
            load(VEC[k][29:18], VEC[k][17], VEC[k][16]);
            rd(0, 0, 0, 1, r); check("R2/R4 lo", r, {1'b1, VEC[k][15:8]});
            rd(0, 0, 1, 0, r); check("R2/R5 hi", r, {1'b1, VEC[k][7:0]});
        end

        // R3: inputs change without a strobe
        load(12'h6B3, 1'b1, 1'b0);
        @(negedge clk);
        mag_i = 12'h19C; pol_i = 1'b0; ovr_i = 1'b1;
        repeat (3) @(negedge clk);
        rd(0, 0, 0, 1, r); check("R3 lo", r, {1'b1, 8'hB3});
        rd(0, 0, 1, 0, r); check("R3 hi", r, {1'b1, 8'h86});

        // R8: both selects low -> numeric byte
        rd(0, 0, 0, 0, r); check("R8", r, {1'b1, 8'hB3});

        // R6 / R9: deselected cases
        rd(0, 1, 0, 1, r); check("R6 cs high", r, 9'h000);
        rd(0, 0, 1, 1, r); check("R6 no byte", r, 9'h000);
        rd(0, 1, 1, 1, r); check("R9 idle zero", r, 9'h000);

        // R7: mode high blocks every select pattern
        rd(1, 0, 0, 1, r); check("R7 lo", r, 9'h000);
        rd(1, 0, 1, 0, r); check("R7 hi", r, 9'h000);
        rd(1, 0, 0, 0, r); check("R7 both", r, 9'h000);

        // R1: reset mid-operation clears the stored word
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(0, 0, 1, 0, r); check("R1 re-reset hi", r, {1'b1, 8'h00});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule